// File: doc/BRIEF.md
# DMA Channel Address Register Unit

This unit keeps the source address, the destination address and the packed control word of one DMA channel thread. A decoder in front of it hands over move commands, which load any one of the three registers with a 32-bit immediate, and add or add-negative commands, which adjust one of the two address registers by a 16-bit unsigned immediate. The transfer engine behind it raises a per-beat advance strobe for each side. On that strobe the matching address steps forward as the control word directs: it can be fixed or incrementing, the element size is a power of two and the burst length runs from one to sixteen elements.

The protection and cache fields of the control word are passed straight through to the bus side. A combinational progress port reports how many bytes an address has moved since a move command last loaded it. Software can use this port to track a running transfer.

Top module: `dma_addr_unit`

## Requirements
- R1: After reset the source and destination addresses are 0, the control word is 0x00004001 (both sides incrementing, 8-bit elements, burst length 1, protection and cache bits zero), and progress reports an error for every selector.
- R2: A move command loads its 32-bit immediate into the register chosen by the selector. The encoding is 0 for the source address, 1 for the control word and 2 for the destination address.
- R3: An add command adds the zero-extended 16-bit immediate to the selected address, and an add-negative command subtracts it. Both wrap modulo 2^32. Arithmetic with selector 1 or 3, or a move with selector 3, raises the reject output in that cycle and changes no register.
- R4: In incrementing mode an advance strobe adds (burst field + 1) << size field bytes to the address, wrapping at 32 bits. The source uses incrementing bit 0, size bits [3:1] and burst bits [7:4]. The destination uses bit 14, bits [17:15] and bits [21:18].
- R5: When a side's incrementing bit is 0, an advance strobe on that side leaves the address unchanged.
- R6: A size field of 5, 6 or 7 on either side raises the size error output, and advance strobes on that side leave its address unchanged.
- R7: The bus-side fields come straight from the control word: source protection from bits [10:8], source cache from [13:11], destination protection from [24:22] and destination cache from [28:25].
- R8: For progress selector 0 or 2, the progress count equals the current address minus the value last loaded by a move into it. Selector 1 or 3, or an address never loaded by a move, raises the progress error and gives a count of 0.
- R9: When a move and an advance hit the same address in one cycle, the move wins. When an add or add-negative and an advance hit the same address, both adjustments apply.
- R10: If several command strobes are high together, move takes priority over add, and add takes priority over add-negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_mov | input | 1 | Move command strobe |
| cmd_add | input | 1 | Add command strobe |
| cmd_sub | input | 1 | Add-negative command strobe |
| cmd_sel | input | 2 | Register selector for the command |
| cmd_imm | input | 32 | Command immediate (low 16 bits for add/add-negative) |
| adv_src | input | 1 | Source beat advance strobe |
| adv_dst | input | 1 | Destination beat advance strobe |
| prog_sel | input | 2 | Register selector for progress |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| ctrl | output | 32 | Current control word |
| src_prot | output | 3 | Source protection bits |
| src_cache | output | 3 | Source cache bits |
| dst_prot | output | 3 | Destination protection bits |
| dst_cache | output | 4 | Destination cache bits |
| cmd_rej | output | 1 | Command rejected this cycle |
| size_err | output | 1 | Illegal element size in the control word |
| prog_cnt | output | 32 | Progress byte count |
| prog_err | output | 1 | Progress request invalid |

## Verification
A decoded command and a beat advance can land on the same address in the same clock. Directed cycles cover both cases: a move together with an advance, and an add or add-negative together with an advance. The random phase also raises advance strobes freely alongside every kind of command. Each outcome is compared with a bench model that resolves the collision by the rules of R9 and R10. The model also covers control-word reloads in the same cycle as an advance, where the step still uses the old word.

// File: rtl/dma_addr_unit.sv
module dma_addr_unit #(
  parameter int          AW       = 32,
  parameter int          IMMW     = 16,
  parameter logic [31:0] CTRL_RST = 32'h0000_4001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_mov,
  input  logic          cmd_add,
  input  logic          cmd_sub,
  input  logic [1:0]    cmd_sel,
  input  logic [31:0]   cmd_imm,
  input  logic          adv_src,
  input  logic          adv_dst,
  input  logic [1:0]    prog_sel,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic [31:0]   ctrl,
  output logic [2:0]    src_prot,
  output logic [2:0]    src_cache,
  output logic [2:0]    dst_prot,
  output logic [3:0]    dst_cache,
  output logic          cmd_rej,
  output logic          size_err,
  output logic [AW-1:0] prog_cnt,
  output logic          prog_err
);

  localparam logic [1:0] SEL_S = 2'd0;
  localparam logic [1:0] SEL_C = 2'd1;
  localparam logic [1:0] SEL_D = 2'd2;

  logic [AW-1:0] s_base, d_base, s_nxt, d_nxt, adj, s_step, d_step;
  logic          s_ld, d_ld;
  logic          hit_s, hit_c, hit_d, arith, neg, s_ok, d_ok;

  assign hit_s = cmd_sel == SEL_S;
  assign hit_c = cmd_sel == SEL_C;
  assign hit_d = cmd_sel == SEL_D;
  assign arith = !cmd_mov && (cmd_add || cmd_sub);
  assign neg   = !cmd_mov && !cmd_add && cmd_sub;

  assign cmd_rej = (cmd_mov && !(hit_s || hit_c || hit_d)) ||
                   (arith && !(hit_s || hit_d));

  assign adj = neg ? (~AW'(cmd_imm[IMMW-1:0]) + AW'(1)) : AW'(cmd_imm[IMMW-1:0]);

  assign s_ok = ctrl[3:1]   <= 3'd4;
  assign d_ok = ctrl[17:15] <= 3'd4;
  assign size_err = !s_ok || !d_ok;

  assign s_step = (adv_src && ctrl[0] && s_ok)
                  ? ((AW'(ctrl[7:4]) + AW'(1)) << ctrl[3:1]) : '0;
  assign d_step = (adv_dst && ctrl[14] && d_ok)
                  ? ((AW'(ctrl[21:18]) + AW'(1)) << ctrl[17:15]) : '0;

  assign s_nxt = (cmd_mov && hit_s) ? cmd_imm[AW-1:0]
               : src_addr + ((arith && hit_s) ? adj : '0) + s_step;
  assign d_nxt = (cmd_mov && hit_d) ? cmd_imm[AW-1:0]
               : dst_addr + ((arith && hit_d) ? adj : '0) + d_step;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_addr <= '0;
      dst_addr <= '0;
      ctrl     <= CTRL_RST;
      s_base   <= '0;
      d_base   <= '0;
      s_ld     <= 1'b0;
      d_ld     <= 1'b0;
    end else begin
      src_addr <= s_nxt;
      dst_addr <= d_nxt;
      if (cmd_mov && hit_c) ctrl <= cmd_imm;
      if (cmd_mov && hit_s) begin
        s_base <= cmd_imm[AW-1:0];
        s_ld   <= 1'b1;
      end
      if (cmd_mov && hit_d) begin
        d_base <= cmd_imm[AW-1:0];
        d_ld   <= 1'b1;
      end
    end
  end

  assign src_prot  = ctrl[10:8];
  assign src_cache = ctrl[13:11];
  assign dst_prot  = ctrl[24:22];
  assign dst_cache = ctrl[28:25];

  assign prog_err = !((prog_sel == SEL_S && s_ld) || (prog_sel == SEL_D && d_ld));
  assign prog_cnt = prog_err ? '0
                  : (prog_sel == SEL_S ? src_addr - s_base : dst_addr - d_base);

  assert_mov_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_mov && cmd_sel == SEL_S) |=> src_addr == $past(cmd_imm[AW-1:0]));

  assert_mov_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_mov && cmd_sel == SEL_C) |=> ctrl == $past(cmd_imm));

  assert_add_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_mov && cmd_add && cmd_sel == SEL_S && !adv_src) |=>
      src_addr == $past(src_addr) + AW'($past(cmd_imm[IMMW-1:0])));

  assert_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_sel == 2'd3 && (cmd_mov || cmd_add || cmd_sub) && !adv_src && !adv_dst) |=>
      ($stable(src_addr) && $stable(dst_addr) && $stable(ctrl)));

  assert_fixed_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !(cmd_sel == SEL_S && (cmd_mov || cmd_add || cmd_sub))) |=>
      $stable(src_addr));

  assert_bad_size_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[3:1] > 3'd4 || ctrl[17:15] > 3'd4) |-> size_err);

  assert_prog_fresh_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_mov && cmd_sel == SEL_D) |=> (prog_sel != SEL_D || (prog_cnt == '0 && !prog_err)));

  assert_mov_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_mov && cmd_sel == SEL_D && adv_dst) |=> dst_addr == $past(cmd_imm[AW-1:0]));

endmodule

// File: tb/sim_dma_addr_unit.sv
module sim_dma_addr_unit;
  logic        clk = 0, rst_n = 0;
  logic        cmd_mov = 0, cmd_add = 0, cmd_sub = 0, adv_src = 0, adv_dst = 0;
  logic [1:0]  cmd_sel = 0, prog_sel = 0;
  logic [31:0] cmd_imm = 0;
  logic [31:0] src_addr, dst_addr, ctrl, prog_cnt;
  logic [2:0]  src_prot, src_cache, dst_prot;
  logic [3:0]  dst_cache;
  logic        cmd_rej, size_err, prog_err;

  int total = 0, bad = 0;
  bit done = 0;

  logic [31:0] m_s, m_d, m_c, m_sb, m_db;
  bit          m_sl, m_dl;

  always #10 clk = ~clk;

  dma_addr_unit u0 (.clk, .rst_n, .cmd_mov, .cmd_add, .cmd_sub, .cmd_sel, .cmd_imm,
    .adv_src, .adv_dst, .prog_sel, .src_addr, .dst_addr, .ctrl, .src_prot, .src_cache,
    .dst_prot, .dst_cache, .cmd_rej, .size_err, .prog_cnt, .prog_err);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] f_step(bit adv, bit inc, logic [2:0] sz, logic [3:0] bl);
    if (!adv || !inc || sz > 4) return 0;
    return (32'(bl) + 1) * (32'd1 << sz);
  endfunction

  function automatic logic [31:0] f_next(logic [31:0] cur, bit mv, bit ad, bit sb, bit hit,
                                         logic [31:0] imm, logic [31:0] step);
    if (mv) return hit ? imm : cur + step;
    if (ad && hit) return cur + {16'h0, imm[15:0]} + step;
    if (sb && hit) return cur - {16'h0, imm[15:0]} + step;
    return cur + step;
  endfunction

  task automatic check_state(string tag);
    chk({tag, " R2 R4 src"}, src_addr, m_s);
    chk({tag, " R2 R4 dst"}, dst_addr, m_d);
    chk({tag, " R2 ctrl"}, ctrl, m_c);
    chk({tag, " R7 pass"}, {src_prot, src_cache, dst_prot, dst_cache},
        {m_c[10:8], m_c[13:11], m_c[24:22], m_c[28:25]});
  endtask

  task automatic step(bit mv, bit ad, bit sb, logic [1:0] sel, logic [31:0] imm,
                      bit as, bit dd, logic [1:0] ps, string tag);
    logic [31:0] ss, ds, ep;
    bit er, rj, arith;
    cmd_mov = mv; cmd_add = ad; cmd_sub = sb; cmd_sel = sel; cmd_imm = imm;
    adv_src = as; adv_dst = dd; prog_sel = ps;
    #1;
    arith = !mv && (ad || sb);
    rj = (mv && sel == 3) || (arith && (sel == 1 || sel == 3));
    chk({tag, " R3 rej"}, 32'(cmd_rej), 32'(rj));
    chk({tag, " R6 szerr"}, 32'(size_err), 32'(m_c[3:1] > 4 || m_c[17:15] > 4));
    er = !((ps == 0 && m_sl) || (ps == 2 && m_dl));
    ep = er ? 0 : (ps == 0 ? m_s - m_sb : m_d - m_db);
    chk({tag, " R8 perr"}, 32'(prog_err), 32'(er));
    chk({tag, " R8 pcnt"}, prog_cnt, ep);
    ss = f_step(as, m_c[0], m_c[3:1], m_c[7:4]);
    ds = f_step(dd, m_c[14], m_c[17:15], m_c[21:18]);
    m_s = f_next(m_s, mv, ad, sb, sel == 0, imm, ss);
    m_d = f_next(m_d, mv, ad, sb, sel == 2, imm, ds);
    if (mv && sel == 1) m_c = imm;
    if (mv && sel == 0) begin m_sb = imm; m_sl = 1; end
    if (mv && sel == 2) begin m_db = imm; m_dl = 1; end
    @(negedge clk);
    check_state(tag);
  endtask

  function automatic logic [31:0] mk_ctrl(bit si, logic [2:0] ss, logic [3:0] sbl,
                                          bit di, logic [2:0] ds, logic [3:0] dbl);
    logic [31:0] c;
    c = 0;
    c[0] = si; c[3:1] = ss; c[7:4] = sbl;
    c[14] = di; c[17:15] = ds; c[21:18] = dbl;
    return c;
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    m_s = 0; m_d = 0; m_c = 32'h0000_4001; m_sb = 0; m_db = 0; m_sl = 0; m_dl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 src", src_addr, 0);
    chk("R1 dst", dst_addr, 0);
    chk("R1 ctrl", ctrl, 32'h0000_4001);
    chk("R1 perr", 32'(prog_err), 1);

    step(1, 0, 0, 0, 32'h0000_1000, 0, 0, 2, "R2 mov src");
    chk("R2 src lit", src_addr, 32'h0000_1000);
    step(1, 0, 0, 1, mk_ctrl(1, 2, 3, 1, 0, 0), 0, 0, 0, "R2 mov ctrl");
    step(0, 0, 0, 0, 0, 1, 1, 0, "R4 adv");
    chk("R4 src +16", src_addr, 32'h0000_1010);
    chk("R4 dst +1", dst_addr, 32'h0000_0001);
    step(0, 0, 0, 0, 0, 0, 0, 0, "R8 prog");
    chk("R8 src prog lit", prog_cnt, 32'h10);
    step(0, 1, 0, 0, 32'hABCD_FFFF, 0, 0, 0, "R3 add");
    chk("R3 add lit", src_addr, 32'h0001_100F);
    step(0, 0, 1, 0, 32'h0000_2000, 0, 0, 0, "R3 sub");
    chk("R3 sub lit", src_addr, 32'h0000_F00F);
    step(0, 1, 0, 1, 32'h0000_0005, 0, 0, 1, "R3 rej ccr");
    chk("R3 ctrl kept", ctrl, mk_ctrl(1, 2, 3, 1, 0, 0));
    step(1, 0, 0, 3, 32'hFFFF_FFFF, 0, 0, 3, "R3 rej sel3");
    step(1, 0, 0, 2, 32'h0000_0004, 0, 0, 2, "R3 wrap setup");
    step(0, 0, 1, 2, 32'h0000_0010, 0, 0, 2, "R3 wrap");
    chk("R3 wrap lit", dst_addr, 32'hFFFF_FFF4);
    step(1, 0, 0, 0, 32'hFFFF_FFF8, 0, 0, 0, "R4 wrap setup");
    step(0, 0, 0, 0, 0, 1, 0, 0, "R4 wrap");
    chk("R4 wrap lit", src_addr, 32'h0000_0008);
    step(1, 0, 0, 1, mk_ctrl(0, 4, 15, 1, 4, 15), 0, 0, 0, "R5 setup");
    step(0, 0, 0, 0, 0, 1, 1, 0, "R5 fixed");
    chk("R5 src fixed", src_addr, 32'h0000_0008);
    chk("R4 dst max step", dst_addr, 32'hFFFF_FFF4 + 256);
    step(1, 0, 0, 1, mk_ctrl(1, 5, 0, 1, 1, 0) | 32'h1AE0_0700, 0, 0, 0, "R6 R7 setup");
    step(0, 0, 0, 0, 0, 1, 1, 0, "R6 blocked");
    chk("R6 src blocked", src_addr, 32'h0000_0008);
    chk("R6 flag", 32'(size_err), 1);
    chk("R7 sprot", 32'(src_prot), 7);
    chk("R7 dcache", 32'(dst_cache), 32'hD);
    step(1, 0, 0, 1, mk_ctrl(1, 0, 1, 1, 0, 1), 0, 0, 0, "R9 setup");
    step(1, 0, 0, 0, 32'h0000_5000, 1, 0, 0, "R9 mov wins");
    chk("R9 mov lit", src_addr, 32'h0000_5000);
    step(0, 1, 0, 0, 32'h0000_0100, 1, 0, 0, "R9 add+adv");
    chk("R9 add lit", src_addr, 32'h0000_5102);
    step(0, 0, 1, 0, 32'h0000_0100, 1, 0, 0, "R9 sub+adv");
    chk("R9 sub lit", src_addr, 32'h0000_5004);
    step(1, 1, 1, 2, 32'h0000_0700, 0, 0, 2, "R10 mov first");
    chk("R10 mov lit", dst_addr, 32'h0000_0700);
    step(0, 1, 1, 2, 32'h0000_0010, 0, 0, 2, "R10 add first");
    chk("R10 add lit", dst_addr, 32'h0000_0710);

    for (int i = 0; i < 4000; i++) begin
      int k;
      bit mv, ad, sb;
      logic [31:0] imm;
      logic [1:0] sel;
      k = $urandom_range(0, 9);
      mv = (k == 0 || k == 1 || k == 8);
      ad = (k == 2 || k == 8 || k == 9);
      sb = (k == 3 || k == 9);
      sel = 2'($urandom_range(0, 3));
      imm = $urandom;
      if (mv && sel == 1)
        imm = mk_ctrl(1'($urandom), 3'($urandom_range(0, 5)), 4'($urandom),
                      1'($urandom), 3'($urandom_range(0, 5)), 4'($urandom)) | (imm & 32'h1FC0_3F00);
      step(mv, ad, sb, sel, imm, 1'($urandom), 1'($urandom), 2'($urandom_range(0, 3)),
           "R9 R10 rand");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule